// File: doc/BRIEF.md
# Grouped Interrupt Arming Controller

This block merges several groups of event sources into a single active-low interrupt request. The request pin has a separate output enable, so the pad floats whenever the controller has nothing to report. Software arms the controller by setting an acknowledge/arm bit. While that bit is high, a group raises the request when its event activity starts. Once a group has raised the request, it stays silent until all of its sources have gone inactive together. Only then can a fresh event from that group be reported.

Every source is a level. Group activity is the OR of that group's sources. A per-group lockout register holds the group activity seen on the previous edge. A group triggers when the arm bit is high, its activity is high, and its lockout is clear, so a trigger is a rising edge of the group OR. Sources that are active while the controller is disarmed set the lockout. Because of this, re-arming does not report an event that is already in progress. Dropping the arm bit floats the request and clears every pending flag.

Top module: `irq_arm_top`

## Requirements
- R1: After reset, irqOe is 0, irqN is 1 and every bit of grpPending is 0.
- R2: If ackArm is 1 on a clock edge, and group g has at least one active source on that edge and had none on the previous edge, then after that edge grpPending[g] is 1, irqOe is 1 and irqN is 0.
- R3: If a group already has an active source, further sources in that group becoming active, or some sources dropping while others stay active, do not cause a new trigger.
- R4: A group triggers again only after all of its sources have been sampled inactive on at least one edge, followed by an edge where one of them is active.
- R5: An edge with ackArm at 0 leaves irqOe at 0, irqN at 1 and grpPending all 0 after that edge.
- R6: Events sampled while ackArm is 0 set no pending flag. A group that is still active when ackArm returns to 1 does not trigger until its sources have all gone inactive and one becomes active again.
- R7: Groups are independent. A group in lockout does not stop another group from triggering and setting its own pending flag.
- R8: irqN is 1 whenever irqOe is 0. irqOe stays 1 from a trigger until an edge with ackArm at 0.
- R9: Source s of group g is the input bit srcEvt[g*SRC_PER_GROUP + s], with group 0 in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEvt | input | NUM_GROUPS*SRC_PER_GROUP | Per-source event levels, grouped contiguously |
| ackArm | input | 1 | Acknowledge/arm control bit; 1 arms the controller |
| irqN | output | 1 | Drive value for the active-low request pin |
| irqOe | output | 1 | Output enable for the request pin; 0 floats the pin |
| grpPending | output | NUM_GROUPS | Per-group flag showing that the group raised the request |

## Verification
The bench builds the block with its default three groups of four sources. With this shape, one group can be held in lockout while a second group triggers. Several sources in one group can also overlap, so a group can stay active while its individual sources change. A behavioural model is compared against the design on every cycle. The stimulus is a mix of directed sequences (disarm while a group is active, then re-arm; overlapping sources; a gap of all sources inactive) and a long stretch of random source and arm activity.

// File: rtl/irq_arm_pkg.sv
package irq_arm_pkg;
  // Strobes from the control part to the per-group datapath
  typedef struct packed {
    logic armed;   // triggers may be accepted on this edge
    logic clrAll;  // drop every pending flag on this edge
  } armStrobe_t;

  typedef enum logic {
    IRQ_IDLE = 1'b0,
    IRQ_HELD = 1'b1
  } irqState_t;
endpackage

// File: rtl/irq_arm_dp.sv
module irq_arm_dp
  import irq_arm_pkg::*;
#(
  parameter int NUM_GROUPS    = 3,
  parameter int SRC_PER_GROUP = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0]   srcEvt,
  input  armStrobe_t                            strobe,
  output logic                                  anyTrig,
  output logic [NUM_GROUPS-1:0]                 grpPending
);
  localparam int NUM_SRC = NUM_GROUPS * SRC_PER_GROUP;

  logic [NUM_GROUPS-1:0] grpAny;
  logic [NUM_GROUPS-1:0] lockQ;
  logic [NUM_GROUPS-1:0] trig;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    // R9: group g owns a contiguous slice of the source vector
    assign grpAny[g] = |srcEvt[g*SRC_PER_GROUP +: SRC_PER_GROUP];

    // Lockout: cleared only once the whole group has gone quiet (R4)
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lockQ[g] <= 1'b0;
      else       lockQ[g] <= grpAny[g];
    end

    assign trig[g] = strobe.armed & grpAny[g] & ~lockQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             grpPending[g] <= 1'b0;
      else if (strobe.clrAll) grpPending[g] <= 1'b0;
      else if (trig[g])       grpPending[g] <= 1'b1;
    end

    // R3: a group still active behind its lockout cannot raise a new pending
    p_no_retrigger_r3: assert property (@(posedge clk) disable iff (!rstN)
      (lockQ[g] && grpAny[g]) |=> !$rose(grpPending[g]));

    // R6: a pending flag only appears after an armed edge
    p_pending_needs_arm_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(grpPending[g]) |-> $past(strobe.armed));
  end

  assign anyTrig = |trig;

  initial begin
    if (NUM_SRC < 1) $error("irq_arm_dp: no sources configured");
  end
endmodule

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl
  import irq_arm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackArm,
  input  logic       anyTrig,
  output armStrobe_t strobe,
  output logic       irqHeld
);
  irqState_t stateQ, stateD;

  always_comb begin
    strobe.armed  = ackArm;
    strobe.clrAll = ~ackArm;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      IRQ_IDLE: if (ackArm && anyTrig) stateD = IRQ_HELD;
      IRQ_HELD: if (!ackArm)           stateD = IRQ_IDLE;
      default:                         stateD = IRQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= IRQ_IDLE;
    else       stateQ <= stateD;
  end

  assign irqHeld = (stateQ == IRQ_HELD);

  // R5: disarming always releases the request
  p_disarm_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ackArm |=> !irqHeld);

  // R2: an armed trigger asserts the request on the next cycle
  p_trigger_asserts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ackArm && anyTrig) |=> irqHeld);

  // R8: the request is held while armed
  p_hold_while_armed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqHeld && ackArm) |=> irqHeld);
endmodule

// File: rtl/irq_arm_top.sv
module irq_arm_top
  import irq_arm_pkg::*;
#(
  parameter int NUM_GROUPS    = 3,
  parameter int SRC_PER_GROUP = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] srcEvt,
  input  logic                                ackArm,
  output logic                                irqN,
  output logic                                irqOe,
  output logic [NUM_GROUPS-1:0]               grpPending
);
  armStrobe_t strobe;
  logic       anyTrig;
  logic       irqHeld;

  irq_arm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ackArm  (ackArm),
    .anyTrig (anyTrig),
    .strobe  (strobe),
    .irqHeld (irqHeld)
  );

  irq_arm_dp #(
    .NUM_GROUPS    (NUM_GROUPS),
    .SRC_PER_GROUP (SRC_PER_GROUP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcEvt     (srcEvt),
    .strobe     (strobe),
    .anyTrig    (anyTrig),
    .grpPending (grpPending)
  );

  // Pin drive: low when enabled, high value while floated (R8)
  assign irqOe = irqHeld;
  assign irqN  = ~irqHeld;

  // R2: the request enable and the pending flags come from separate logic and must agree
  p_enable_matches_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqOe == (|grpPending));
endmodule

// File: tb/irq_arm_top_tb_top.sv
module irq_arm_top_tb_top;
  localparam int NG  = 3;
  localparam int SPG = 4;
  localparam int NS  = NG * SPG;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcEvt = '0;
  logic          ackArm = 1'b0;
  logic          irqN;
  logic          irqOe;
  logic [NG-1:0] grpPending;

  int    compared = 0;
  int    mismatched = 0;
  string curReq = "R1";
  bit    started = 0;

  // reference state
  bit    mPrev [NG];
  bit    mPend [NG];
  bit    mIrq;

  always #2.5 clk = ~clk;  // 200 MHz

  irq_arm_top #(.NUM_GROUPS(NG), .SRC_PER_GROUP(SPG)) dut_i (
    .clk(clk), .rstN(rstN), .srcEvt(srcEvt), .ackArm(ackArm),
    .irqN(irqN), .irqOe(irqOe), .grpPending(grpPending)
  );

  initial begin
    for (int g = 0; g < NG; g++) begin mPrev[g] = 0; mPend[g] = 0; end
    mIrq = 0;
  end

  // Behavioural reference: edge of group activity, armed, sets pending
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NG; g++) begin mPrev[g] = 0; mPend[g] = 0; end
      mIrq = 0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        bit act;
        act = 0;
        for (int s = 0; s < SPG; s++) if (srcEvt[g*SPG + s]) act = 1;
        if (!ackArm) mPend[g] = 0;
        else if (act && !mPrev[g]) begin mPend[g] = 1; mIrq = 1; end
        mPrev[g] = act;
      end
      if (!ackArm) mIrq = 0;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      logic [NG-1:0] expPend;
      for (int g = 0; g < NG; g++) expPend[g] = mPend[g];
      compared++;
      if (irqOe !== mIrq || irqN !== !mIrq || grpPending !== expPend) begin
        mismatched++;
        $display("FAIL %s t=%0t: irqOe=%b irqN=%b pend=%b expected irqOe=%b irqN=%b pend=%b",
                 curReq, $time, irqOe, irqN, grpPending, mIrq, !mIrq, expPend);
      end
    end
  end

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setSrc(input int g, input int s, input bit v);
    srcEvt[g*SPG + s] = v;  // R9 mapping
  endtask

  task automatic directCheck(input string tag, input bit expOe, input logic [NG-1:0] expPend);
    compared++;
    if (irqOe !== expOe || irqN !== !expOe || grpPending !== expPend) begin
      mismatched++;
      $display("FAIL %s direct: irqOe=%b pend=%b expected irqOe=%b pend=%b",
               tag, irqOe, grpPending, expOe, expPend);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state
    started = 1;
    stepN(3);
    directCheck("R1", 1'b0, 3'b000);
    rstN = 1'b1;
    stepN(2);

    // R2: armed rising activity in group 0, source 1
    curReq = "R2";
    ackArm = 1'b1;
    stepN(1);
    setSrc(0, 1, 1);
    stepN(1);
    directCheck("R2", 1'b1, 3'b001);

    // R3: overlapping sources in group 0 do not retrigger
    curReq = "R3";
    ackArm = 1'b0; stepN(1);
    directCheck("R5", 1'b0, 3'b000);
    ackArm = 1'b1;
    setSrc(0, 3, 1); stepN(1);
    setSrc(0, 1, 0); stepN(2);
    directCheck("R3", 1'b0, 3'b000);

    // R7: group 2 source 0 (bit 8) triggers while group 0 locked
    curReq = "R7";
    setSrc(2, 0, 1); stepN(1);
    directCheck("R7", 1'b1, 3'b100);

    // R4: group 0 quiet for one edge, then fires again
    curReq = "R4";
    setSrc(0, 3, 0); stepN(1);
    directCheck("R4", 1'b1, 3'b100);
    setSrc(0, 2, 1); stepN(1);
    directCheck("R4", 1'b1, 3'b101);

    // R6: events while disarmed set nothing; still-active group ignored on re-arm
    curReq = "R6";
    ackArm = 1'b0;
    srcEvt = '0; stepN(1);
    setSrc(1, 2, 1); stepN(2);
    directCheck("R6", 1'b0, 3'b000);
    ackArm = 1'b1; stepN(2);
    directCheck("R6", 1'b0, 3'b000);
    setSrc(1, 2, 0); stepN(1);
    setSrc(1, 0, 1); stepN(1);
    directCheck("R6", 1'b1, 3'b010);

    // R8: held while armed, then floated high on disarm
    curReq = "R8";
    srcEvt = '0; stepN(3);
    directCheck("R8", 1'b1, 3'b010);
    ackArm = 1'b0; stepN(1);
    directCheck("R8", 1'b0, 3'b000);

    // Random stretch compared against the model every cycle
    curReq = "R2..R8 random";
    for (int i = 0; i < 3000; i++) begin
      srcEvt = NS'($urandom_range(0, (1 << NS) - 1) & $urandom_range(0, (1 << NS) - 1));
      if ($urandom_range(0, 15) == 0) ackArm = ~ackArm;
      stepN(1);
    end
    stepN(2);
    finishRun();
  end
endmodule